// File: doc/BRIEF.md
# Code-Offset Helper Data Unit

This block is the datapath that turns a physically unclonable response into a reproducible value, using the code-offset construction over a systematic linear block code. In enrolment it encodes a message drawn from the PUF into a codeword C and masks the full-width response R with it. The helper data P = R XOR C is what gets stored off-block. In reconstruction it masks a fresh, noisy response R' with the stored helper data. Because the code is linear, this gives a noisy copy of C. That word goes to an external bit-flipping decoder, and R is then rebuilt as the decoded codeword XOR P.

A mode input chooses the operation and a start strobe launches it. Completion is marked by a one-cycle done strobe with an ok/error status, and all outputs hold from done until the next accepted start. The code is set by a codeword width and a rate selector. The selector picks 1/2, 2/3 or 3/4 and so sets the message width (64 bits at the default 128-bit codeword, rate 1/2). Only the parity structure changes with the rate; the encoder framework stays the same.

Top module: `cofs_helper_unit`

## Requirements
- R1: Enrolment: when `start` is high with `mode`=0 while the unit is idle, the next cycle shows `done`=1, `ok`=1, `err`=0, `resp_out`=0 and `helper_out` = `resp_in` XOR C, with `resp_in` and `msg_in` taken at the start edge.
- R2: Codeword format at the default (K=64 message bits, N=128 codeword bits, NP=N-K=64 parity bits): C[N-1:NP] = `msg_in`. For every j < NP, C[j] = m[j mod K] XOR m[(j+1) mod K] XOR m[(j+5) mod K].
- R3: Reconstruction: when `start` is high with `mode`=1 while idle, the next cycle shows `dec_req_valid`=1 and `dec_req_word` = `resp_in` XOR `helper_in`, both taken at the start edge. `helper_in` is also kept internally, so later changes to it have no effect, and `helper_out` reads 0 from that cycle on.
- R4: While `dec_req_valid` is high and `dec_req_ready` is low, the request stays asserted and `dec_req_word` does not change.
- R5: After the request handshake, `dec_req_valid` is low and `dec_rsp_ready` is high. On a response with `dec_rsp_fail`=0, the next cycle shows `done`=1, `ok`=1, `err`=0 and `resp_out` = `dec_rsp_word` XOR the kept helper data.
- R6: On a response with `dec_rsp_fail`=1, the next cycle shows `done`=1, `err`=1, `ok`=0 and `resp_out`=0.
- R7: A `start` that arrives while a reconstruction is in flight is ignored. This includes the cycle in which the decoder response is accepted. It produces no `done` and launches no request.
- R8: While idle with no `start`, `helper_out`, `resp_out`, `ok` and `err` hold their values. A `start` in the same cycle as `done` is accepted, so enrolments can run back to back.
- R9: During and straight after reset, `done`, `ok`, `err`, `dec_req_valid` and `dec_rsp_ready` are 0, and `helper_out` and `resp_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe for the selected operation |
| mode | input | 1 | 0 = enrol, 1 = reconstruct |
| msg_in | input | MSG_W | Message to encode during enrolment |
| resp_in | input | CW_W | PUF response (R at enrolment, R' at reconstruction) |
| helper_in | input | CW_W | Stored helper data for reconstruction |
| dec_req_valid | output | 1 | Noisy codeword offered to the decoder |
| dec_req_ready | input | 1 | Decoder accepts the noisy codeword |
| dec_req_word | output | CW_W | Noisy codeword R' XOR P |
| dec_rsp_valid | input | 1 | Decoder result present |
| dec_rsp_ready | output | 1 | Unit is waiting for the decoder result |
| dec_rsp_word | input | CW_W | Decoded codeword |
| dec_rsp_fail | input | 1 | Decoder could not converge |
| done | output | 1 | One-cycle completion strobe |
| ok | output | 1 | Last operation succeeded |
| err | output | 1 | Last reconstruction failed in the decoder |
| helper_out | output | CW_W | Helper data from enrolment |
| resp_out | output | CW_W | Recovered response from reconstruction |

## Verification
Two functions can meet in one cycle. The first is a new launch strobe arriving while the decoder result is being accepted. The bench holds `start` high with enrol mode through that response cycle and requires exactly one completion, carrying the reconstruction result, with no enrolment result and no new request after it. The second is a launch in the very cycle of a completion strobe. The bench keeps `start` high across two edges with fresh inputs and expects two enrolment results, each matching its own inputs, on consecutive cycles.

// File: rtl/cofs_pkg.sv
package cofs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } cofs_state_e;

    // Message width for a codeword width and a rate selector (0: 1/2, 1: 2/3, 2: 3/4).
    function automatic int rate_msg_bits(input int cw_bits, input int rate_sel);
        case (rate_sel)
            1:       return (cw_bits * 2) / 3;
            2:       return (cw_bits * 3) / 4;
            default: return cw_bits / 2;
        endcase
    endfunction

    // Offsets of the message taps folded into each parity bit.
    localparam int TAP_A = 0;
    localparam int TAP_B = 1;
    localparam int TAP_C = 5;

endpackage

// File: rtl/cofs_encoder.sv
module cofs_encoder
    import cofs_pkg::*;
#(
    parameter int CW_W  = 128,
    parameter int MSG_W = 64
) (
    input  logic [MSG_W-1:0] msg,
    output logic [CW_W-1:0]  codeword
);
    localparam int NP_W = CW_W - MSG_W;

    // Systematic part: message sits above the parity field.
    assign codeword[CW_W-1:NP_W] = msg;

    // Each parity bit is a GF(2) sum of three message bits.
    for (genvar j = 0; j < NP_W; j++) begin : g_par
        localparam int IA = (j + TAP_A) % MSG_W;
        localparam int IB = (j + TAP_B) % MSG_W;
        localparam int IC = (j + TAP_C) % MSG_W;
        assign codeword[j] = msg[IA] ^ msg[IB] ^ msg[IC];
    end

endmodule

// File: rtl/cofs_ctrl.sv
module cofs_ctrl
    import cofs_pkg::*;
#(
    parameter int CW_W = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            mode,
    input  logic [CW_W-1:0] enc_word,
    input  logic [CW_W-1:0] resp_in,
    input  logic [CW_W-1:0] helper_in,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [CW_W-1:0] req_word,
    input  logic            rsp_valid,
    output logic            rsp_ready,
    input  logic [CW_W-1:0] rsp_word,
    input  logic            rsp_fail,
    output logic            done,
    output logic            ok,
    output logic            err,
    output logic [CW_W-1:0] helper_out,
    output logic [CW_W-1:0] resp_out
);

    typedef struct packed {
        cofs_state_e     state;
        logic [CW_W-1:0] req_word;
        logic [CW_W-1:0] mask;
        logic [CW_W-1:0] helper_out;
        logic [CW_W-1:0] resp_out;
        logic            done;
        logic            ok;
        logic            err;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.ok       = 1'b0;
                    st_d.err      = 1'b0;
                    st_d.resp_out = '0;
                    if (!mode) begin
                        st_d.helper_out = resp_in ^ enc_word;
                        st_d.done       = 1'b1;
                        st_d.ok         = 1'b1;
                    end else begin
                        st_d.helper_out = '0;
                        st_d.mask       = helper_in;
                        st_d.req_word   = resp_in ^ helper_in;
                        st_d.state      = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (req_ready) st_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    st_d.state = ST_IDLE;
                    st_d.done  = 1'b1;
                    if (rsp_fail) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.ok       = 1'b1;
                        st_d.resp_out = rsp_word ^ st_q.mask;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid  = (st_q.state == ST_SEND);
    assign rsp_ready  = (st_q.state == ST_WAIT);
    assign req_word   = st_q.req_word;
    assign done       = st_q.done;
    assign ok         = st_q.ok;
    assign err        = st_q.err;
    assign helper_out = st_q.helper_out;
    assign resp_out   = st_q.resp_out;

    // R3: a reconstruct launch offers R' xor P on the next cycle.
    p_recon_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_IDLE && start && mode) |=>
            (req_valid && req_word == $past(resp_in ^ helper_in)));

    // R4: an unaccepted request is held unchanged.
    p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_word)));

    // R6: a failed decode never exposes a response.
    p_fail_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (resp_out == '0 && !ok));

    // R7: a launch while busy produces no completion, except the response itself.
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_SEND && start) |=> !done);

    // R8: idle without a launch keeps every result stable.
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_IDLE && !start) |=>
            ($stable(helper_out) && $stable(resp_out) && $stable(ok) && $stable(err)));

endmodule

// File: rtl/cofs_helper_unit.sv
module cofs_helper_unit
    import cofs_pkg::*;
#(
    parameter int CW_W     = 128,
    parameter int RATE_SEL = 0,
    localparam int MSG_W   = rate_msg_bits(CW_W, RATE_SEL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [MSG_W-1:0] msg_in,
    input  logic [CW_W-1:0]  resp_in,
    input  logic [CW_W-1:0]  helper_in,
    output logic             dec_req_valid,
    input  logic             dec_req_ready,
    output logic [CW_W-1:0]  dec_req_word,
    input  logic             dec_rsp_valid,
    output logic             dec_rsp_ready,
    input  logic [CW_W-1:0]  dec_rsp_word,
    input  logic             dec_rsp_fail,
    output logic             done,
    output logic             ok,
    output logic             err,
    output logic [CW_W-1:0]  helper_out,
    output logic [CW_W-1:0]  resp_out
);

    logic [CW_W-1:0] enc_word;

    cofs_encoder #(
        .CW_W  (CW_W),
        .MSG_W (MSG_W)
    ) i_enc (
        .msg      (msg_in),
        .codeword (enc_word)
    );

    cofs_ctrl #(
        .CW_W (CW_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .enc_word   (enc_word),
        .resp_in    (resp_in),
        .helper_in  (helper_in),
        .req_valid  (dec_req_valid),
        .req_ready  (dec_req_ready),
        .req_word   (dec_req_word),
        .rsp_valid  (dec_rsp_valid),
        .rsp_ready  (dec_rsp_ready),
        .rsp_word   (dec_rsp_word),
        .rsp_fail   (dec_rsp_fail),
        .done       (done),
        .ok         (ok),
        .err        (err),
        .helper_out (helper_out),
        .resp_out   (resp_out)
    );

    // R1: an enrol launch from idle yields done/ok and R xor C one cycle later.
    p_enrol_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode && !dec_req_valid && !dec_rsp_ready) |=>
            (done && ok && !err && helper_out == $past(resp_in ^ enc_word)));

    // R5: the unit waits for the response only after the request is gone.
    p_rsp_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_req_valid && dec_rsp_ready));

endmodule

// File: tb/test_cofs_helper_unit.sv
module test_cofs_helper_unit;
    localparam int CW = 128;
    localparam int K  = 64;
    localparam int NP = CW - K;

    typedef struct {
        logic [CW-1:0] helper;
        logic [CW-1:0] resp;
        logic          ok;
        logic          err;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, mode = 1'b0;
    logic [K-1:0]  msg_in = '0;
    logic [CW-1:0] resp_in = '0, helper_in = '0;
    logic          dec_req_valid, dec_req_ready = 1'b0;
    logic [CW-1:0] dec_req_word;
    logic          dec_rsp_valid = 1'b0, dec_rsp_ready, dec_rsp_fail = 1'b0;
    logic [CW-1:0] dec_rsp_word = '0;
    logic          done, ok, err;
    logic [CW-1:0] helper_out, resp_out;

    int   n_chk = 0, n_fail = 0;
    bit   finished = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    cofs_helper_unit i_cofs_helper_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .msg_in(msg_in),
        .resp_in(resp_in), .helper_in(helper_in),
        .dec_req_valid(dec_req_valid), .dec_req_ready(dec_req_ready),
        .dec_req_word(dec_req_word), .dec_rsp_valid(dec_rsp_valid),
        .dec_rsp_ready(dec_rsp_ready), .dec_rsp_word(dec_rsp_word),
        .dec_rsp_fail(dec_rsp_fail), .done(done), .ok(ok), .err(err),
        .helper_out(helper_out), .resp_out(resp_out)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] expv);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // R2 codeword built from the requirement text.
    function automatic logic [CW-1:0] cw_of(input logic [K-1:0] m);
        logic [CW-1:0] c;
        c[CW-1:NP] = m;
        for (int j = 0; j < NP; j++)
            c[j] = m[j % K] ^ m[(j + 1) % K] ^ m[(j + 5) % K];
        return c;
    endfunction

    function automatic logic [CW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Monitor: every done pops and compares one expected item.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(0, "R7", "done with nothing expected", 128'd1, 128'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(helper_out == e.helper, e.req, "helper_out", helper_out, e.helper);
                chk(resp_out == e.resp, e.req, "resp_out", resp_out, e.resp);
                chk(ok == e.ok, e.req, "ok", {127'd0, ok}, {127'd0, e.ok});
                chk(err == e.err, e.req, "err", {127'd0, err}, {127'd0, e.err});
            end
        end
    end

    task automatic enrol(input logic [K-1:0] m, input logic [CW-1:0] r, input string req);
        exp_t e;
        @(negedge clk);
        mode = 1'b0; msg_in = m; resp_in = r; start = 1'b1;
        e.helper = r ^ cw_of(m); e.resp = '0; e.ok = 1'b1; e.err = 1'b0; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic recon(input logic [CW-1:0] rn, input logic [CW-1:0] p,
                         input logic [CW-1:0] dword, input bit fail);
        exp_t e;
        @(negedge clk);
        mode = 1'b1; resp_in = rn; helper_in = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(dec_req_valid == 1'b1, "R3", "req_valid", {127'd0, dec_req_valid}, 128'd1);
        chk(dec_req_word == (rn ^ p), "R3", "req_word", dec_req_word, rn ^ p);
        chk(helper_out == '0, "R3", "helper_out cleared", helper_out, '0);
        resp_in = ~rn; helper_in = ~p;
        @(negedge clk);
        chk(dec_req_valid && dec_req_word == (rn ^ p), "R4", "held request",
            dec_req_word, rn ^ p);
        dec_req_ready = 1'b1;
        @(negedge clk);
        dec_req_ready = 1'b0;
        chk(dec_rsp_ready && !dec_req_valid, "R5", "response phase",
            {126'd0, dec_rsp_ready, dec_req_valid}, 128'd2);
        mode = 1'b0; start = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R7", "start while busy", {127'd0, done}, 128'd0);
        e.helper = '0; e.resp = fail ? '0 : (dword ^ p);
        e.ok = !fail; e.err = fail; e.req = fail ? "R6" : "R5";
        sb.push_back(e);
        dec_rsp_valid = 1'b1; dec_rsp_word = dword; dec_rsp_fail = fail;
        @(negedge clk);
        dec_rsp_valid = 1'b0; start = 1'b0;
        @(negedge clk);
        chk(!done && !dec_req_valid && !dec_rsp_ready, "R7", "start on response ignored",
            {125'd0, done, dec_req_valid, dec_rsp_ready}, 128'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        logic [K-1:0]  m;
        logic [CW-1:0] r, p, c, h_sv, r_sv;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!done && !ok && !err && !dec_req_valid && !dec_rsp_ready, "R9", "flags in reset",
            {123'd0, done, ok, err, dec_req_valid, dec_rsp_ready}, 128'd0);
        chk(helper_out == '0 && resp_out == '0, "R9", "data in reset", helper_out | resp_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !ok && !err && !dec_req_valid, "R9", "after reset",
            {124'd0, done, ok, err, dec_req_valid}, 128'd0);

        // R2 codeword visible directly with a zero response
        enrol('0, '0, "R2");
        enrol({K{1'b1}}, '0, "R2");
        enrol(64'h1, '0, "R2");
        enrol(64'h8000_0000_0000_0000, '0, "R2");
        // R1 masking with varied responses
        for (int i = 0; i < 4; i++) enrol({$urandom, $urandom}, rnd128(), "R1");
        repeat (2) @(negedge clk);

        // R8 back-to-back enrolments: start held across the done cycle
        begin
            exp_t e;
            m = {$urandom, $urandom}; r = rnd128();
            mode = 1'b0; msg_in = m; resp_in = r; start = 1'b1;
            e.helper = r ^ cw_of(m); e.resp = '0; e.ok = 1; e.err = 0; e.req = "R8";
            sb.push_back(e);
            @(negedge clk);
            m = ~m; r = rnd128();
            msg_in = m; resp_in = r;
            e.helper = r ^ cw_of(m);
            sb.push_back(e);
            @(negedge clk);
            start = 1'b0;
        end

        // R8 hold: inputs move, no start, outputs stay
        @(negedge clk);
        h_sv = helper_out; r_sv = resp_out;
        for (int i = 0; i < 3; i++) begin
            msg_in = {$urandom, $urandom}; resp_in = rnd128(); mode = i[0];
            @(negedge clk);
            chk(helper_out == h_sv && resp_out == r_sv && ok, "R8", "hold while idle",
                helper_out, h_sv);
        end

        // R5 reconstruction with several noise patterns; decoder returns C
        for (int i = 0; i < 4; i++) begin
            m = {$urandom, $urandom}; r = rnd128(); c = cw_of(m); p = r ^ c;
            case (i)
                0: recon(r, p, c, 1'b0);
                1: recon(r ^ 128'h1, p, c, 1'b0);
                2: recon(r ^ {1'b1, 126'd0, 1'b1}, p, c, 1'b0);
                default: recon(r ^ rnd128(), p, c, 1'b0);
            endcase
        end
        // R6 decoder failure
        recon(rnd128(), rnd128(), rnd128(), 1'b1);
        @(negedge clk);
        chk(err && !ok && resp_out == '0, "R6", "failure held", resp_out, '0);
        // new start clears the error flag
        enrol('0, '0, "R1");
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R7", "all results seen", sb.size(), '0);
        summary();
    end
endmodule